// File: doc/BRIEF.md
# Table Read Pointer Unit

This unit fetches constant data stored in program memory. Software keeps a byte-wide table pointer, which it can load, step up or step down. A table-read command carries a destination register address. It starts a program-memory access at the location the pointer names, within a fixed page. When the wide program word returns, the unit splits it into two parts. The part above the low byte is latched into a dedicated high-byte register, which the data bus can only read. The low byte goes out on a writeback port to the register chosen by the command.

A small state machine runs each access over two cycles. The states are IDLE, ISSUE and CAPTURE. The IDLE to ISSUE transition happens when a read request arrives. ISSUE to CAPTURE always follows in the next cycle, and so does CAPTURE to IDLE. In ISSUE the unit drives the program-memory read strobe and address. In CAPTURE it takes in the returned word and performs the writeback. A busy flag is high in ISSUE and in CAPTURE.

Top module: `tblrd_unit`

## Requirements
- R1: After reset the pointer and the high-byte register read 0x00, and busy, pm_rd_en and wb_en are all low.
- R2: When ptr_wr_en is high, the pointer takes ptr_wr_data at the next edge. This holds even if ptr_inc or ptr_dec is also high.
- R3: If ptr_inc is high and ptr_wr_en and ptr_dec are low, the pointer increases by one modulo 256, so 0xFF becomes 0x00. If ptr_dec is high and ptr_wr_en and ptr_inc are low, the pointer decreases by one modulo 256, so 0x00 becomes 0xFF. If ptr_inc and ptr_dec are both high and ptr_wr_en is low, the pointer is left unchanged.
- R4: A rd_req accepted while busy is low is followed in the next cycle by exactly one cycle of pm_rd_en. During that cycle pm_addr carries PAGE in its upper ADDR_W-8 bits and, in its low 8 bits, the pointer value held in the request cycle. A write to the pointer in that same request cycle does not change the address.
- R5: The cycle after pm_rd_en is the capture cycle. In it, wb_en is high for one cycle, wb_addr equals the rd_dst given with the request, and wb_data equals bits [7:0] of pm_rd_data.
- R6: After the capture cycle, hi_q holds bits [WORD_W-1:8] of the fetched word, with every bit above them reading zero. hi_q keeps that value until the next capture, whatever the pointer does in between.
- R7: busy is high in exactly the ISSUE and CAPTURE cycles. A rd_req that arrives while busy is high starts no access, and its rd_dst is not used.
- R8: Changes to the pointer during an access take effect as normal. They do not alter the address or the writeback data of the access already under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ptr_wr_en | input | 1 | Load the pointer from ptr_wr_data |
| ptr_wr_data | input | 8 | Value to load into the pointer |
| ptr_inc | input | 1 | Step the pointer up by one |
| ptr_dec | input | 1 | Step the pointer down by one |
| rd_req | input | 1 | Table-read command |
| rd_dst | input | DST_W | Destination register address for the low byte |
| pm_rd_en | output | 1 | Program-memory read strobe |
| pm_addr | output | ADDR_W | Program-memory address (page and pointer) |
| pm_rd_data | input | WORD_W | Program word, valid the cycle after pm_rd_en |
| wb_en | output | 1 | Writeback strobe for the low byte |
| wb_addr | output | DST_W | Writeback destination address |
| wb_data | output | 8 | Low byte of the fetched word |
| ptr_q | output | 8 | Current pointer value |
| hi_q | output | 8 | High-byte register, zero-extended |
| busy | output | 1 | An access is in progress |

## Verification
Some properties are checked on every cycle. After an idle request the read strobe must follow. The strobe never lasts two cycles and is always followed by the writeback. The address always stays in the fixed page. busy must match the strobes. Pointer loads and steps must give the right values, and the high-byte register must stay unchanged outside capture. Other behaviour only the bench scenarios can show. These are that the address uses the pointer from the request cycle and not a value written at the same time, and that the data split and zero extension come out right for chosen words. They also include that stray requests while busy go unused, and that pointer changes during an access leave the access alone.

// File: rtl/tblrd_pkg.sv
package tblrd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ISSUE   = 2'd1,
        ST_CAPTURE = 2'd2
    } tblrd_state_e;

    typedef enum logic [1:0] {
        PTR_HOLD = 2'd0,
        PTR_LOAD = 2'd1,
        PTR_UP   = 2'd2,
        PTR_DOWN = 2'd3
    } ptr_op_e;

    // Load beats stepping; opposing steps cancel.
    function automatic ptr_op_e ptr_op_sel(input logic wr, input logic up, input logic down);
        if (wr)
            return PTR_LOAD;
        else if (up && !down)
            return PTR_UP;
        else if (down && !up)
            return PTR_DOWN;
        else
            return PTR_HOLD;
    endfunction

endpackage

// File: rtl/tblrd_ptr.sv
module tblrd_ptr
    import tblrd_pkg::*;
#(
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_data,
    input  logic             step_up,
    input  logic             step_down,
    output logic [PTR_W-1:0] ptr_q
);

    localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

    ptr_op_e          op;
    logic [PTR_W-1:0] ptr_d;

    assign op = ptr_op_sel(wr_en, step_up, step_down);

    always_comb begin
        unique case (op)
            PTR_LOAD: ptr_d = wr_data;
            PTR_UP:   ptr_d = ptr_q + ONE;
            PTR_DOWN: ptr_d = ptr_q - ONE;
            default:  ptr_d = ptr_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ptr_q <= '0;
        else
            ptr_q <= ptr_d;
    end

endmodule

// File: rtl/tblrd_fsm.sv
module tblrd_fsm
    import tblrd_pkg::*;
#(
    parameter int PTR_W = 8,
    parameter int DST_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [DST_W-1:0] req_dst,
    input  logic [PTR_W-1:0] ptr_cur,
    output logic             issue,
    output logic             capture,
    output logic             busy,
    output logic [PTR_W-1:0] acc_ptr,
    output logic [DST_W-1:0] acc_dst
);

    tblrd_state_e state_q, state_d;
    logic         accept;

    assign accept = (state_q == ST_IDLE) && req;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Transitions
    always_comb begin
        unique case (state_q)
            ST_IDLE:    state_d = req ? ST_ISSUE : ST_IDLE;
            ST_ISSUE:   state_d = ST_CAPTURE;
            ST_CAPTURE: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Access context, frozen when the request is accepted
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_ptr <= '0;
            acc_dst <= '0;
        end else if (accept) begin
            acc_ptr <= ptr_cur;
            acc_dst <= req_dst;
        end
    end

    // Outputs
    always_comb begin
        issue   = 1'b0;
        capture = 1'b0;
        busy    = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ISSUE: begin
                issue = 1'b1;
                busy  = 1'b1;
            end
            ST_CAPTURE: begin
                capture = 1'b1;
                busy    = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/tblrd_hold.sv
module tblrd_hold #(
    parameter int WORD_W = 14,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [WORD_W-1:0] word,
    output logic [BYTE_W-1:0] lo_byte,
    output logic [BYTE_W-1:0] hi_q
);

    localparam int HI_W = WORD_W - BYTE_W;

    logic [BYTE_W-1:0] hi_d;

    assign lo_byte = word[BYTE_W-1:0];

    generate
        if (HI_W >= BYTE_W) begin : g_full
            assign hi_d = word[BYTE_W +: BYTE_W];
        end else begin : g_pad
            assign hi_d = {{(BYTE_W-HI_W){1'b0}}, word[WORD_W-1:BYTE_W]};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hi_q <= '0;
        else if (capture)
            hi_q <= hi_d;
    end

endmodule

// File: rtl/tblrd_unit.sv
module tblrd_unit #(
    parameter int ADDR_W = 12,
    parameter int WORD_W = 14,
    parameter int DST_W  = 7,
    parameter logic [ADDR_W-9:0] PAGE = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_wr_en,
    input  logic [7:0]        ptr_wr_data,
    input  logic              ptr_inc,
    input  logic              ptr_dec,
    input  logic              rd_req,
    input  logic [DST_W-1:0]  rd_dst,
    output logic              pm_rd_en,
    output logic [ADDR_W-1:0] pm_addr,
    input  logic [WORD_W-1:0] pm_rd_data,
    output logic              wb_en,
    output logic [DST_W-1:0]  wb_addr,
    output logic [7:0]        wb_data,
    output logic [7:0]        ptr_q,
    output logic [7:0]        hi_q,
    output logic              busy
);

    localparam int PTR_W = 8;

    logic [PTR_W-1:0] acc_ptr;
    logic             issue;
    logic             capture;

    tblrd_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (ptr_wr_en),
        .wr_data   (ptr_wr_data),
        .step_up   (ptr_inc),
        .step_down (ptr_dec),
        .ptr_q     (ptr_q)
    );

    tblrd_fsm #(.PTR_W(PTR_W), .DST_W(DST_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (rd_req),
        .req_dst (rd_dst),
        .ptr_cur (ptr_q),
        .issue   (issue),
        .capture (capture),
        .busy    (busy),
        .acc_ptr (acc_ptr),
        .acc_dst (wb_addr)
    );

    tblrd_hold #(.WORD_W(WORD_W), .BYTE_W(PTR_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .word    (pm_rd_data),
        .lo_byte (wb_data),
        .hi_q    (hi_q)
    );

    assign pm_rd_en = issue;
    assign pm_addr  = {PAGE, acc_ptr};
    assign wb_en    = capture;

endmodule

// File: rtl/tblrd_unit_chk.sv
module tblrd_unit_chk #(
    parameter int ADDR_W = 12,
    parameter int DST_W  = 7,
    parameter logic [ADDR_W-9:0] PAGE = '1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ptr_wr_en,
    input logic [7:0]        ptr_wr_data,
    input logic              ptr_inc,
    input logic              ptr_dec,
    input logic              rd_req,
    input logic              pm_rd_en,
    input logic [ADDR_W-1:0] pm_addr,
    input logic              wb_en,
    input logic [7:0]        ptr_q,
    input logic [7:0]        hi_q,
    input logic              busy
);

    // R4
    issue_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !busy) |=> pm_rd_en);

    // R4
    page_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pm_rd_en |-> (pm_addr[ADDR_W-1:8] == PAGE));

    // R7
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pm_rd_en |=> !pm_rd_en);

    // R5
    wb_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pm_rd_en |=> wb_en);

    // R7
    busy_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy == (pm_rd_en || wb_en));

    // R2
    ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_wr_en |=> (ptr_q == $past(ptr_wr_data)));

    // R3
    ptr_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_inc && !ptr_dec && !ptr_wr_en) |=> (ptr_q == 8'($past(ptr_q) + 8'd1)));

    // R3
    ptr_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_dec && !ptr_inc && !ptr_wr_en) |=> (ptr_q == 8'($past(ptr_q) - 8'd1)));

    // R6
    hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_en |=> $stable(hi_q));

endmodule

bind tblrd_unit tblrd_unit_chk #(.ADDR_W(ADDR_W), .DST_W(DST_W), .PAGE(PAGE)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ptr_wr_en   (ptr_wr_en),
    .ptr_wr_data (ptr_wr_data),
    .ptr_inc     (ptr_inc),
    .ptr_dec     (ptr_dec),
    .rd_req      (rd_req),
    .pm_rd_en    (pm_rd_en),
    .pm_addr     (pm_addr),
    .wb_en       (wb_en),
    .ptr_q       (ptr_q),
    .hi_q        (hi_q),
    .busy        (busy)
);

// File: tb/tb_tblrd_unit.sv
module tb_tblrd_unit;

    localparam int ADDR_W = 12;
    localparam int WORD_W = 14;
    localparam int DST_W  = 7;
    localparam logic [3:0] PAGE = 4'hF;
    localparam int NVEC = 6;
    // each entry: {pointer value, destination}
    localparam logic [14:0] VEC [NVEC] = '{
        {8'h00, 7'h10}, {8'hFF, 7'h7F}, {8'h5A, 7'h01},
        {8'h80, 7'h00}, {8'h01, 7'h55}, {8'h7F, 7'h2A}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ptr_wr_en = 1'b0;
    logic [7:0]        ptr_wr_data = '0;
    logic              ptr_inc = 1'b0;
    logic              ptr_dec = 1'b0;
    logic              rd_req = 1'b0;
    logic [DST_W-1:0]  rd_dst = '0;
    logic              pm_rd_en;
    logic [ADDR_W-1:0] pm_addr;
    logic [WORD_W-1:0] pm_rd_data = '0;
    logic              wb_en;
    logic [DST_W-1:0]  wb_addr;
    logic [7:0]        wb_data;
    logic [7:0]        ptr_q;
    logic [7:0]        hi_q;
    logic              busy;

    int tests = 0;
    int fails = 0;
    int rd_cnt = 0;
    int wb_cnt = 0;

    always #2.5 clk = ~clk;

    tblrd_unit #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .DST_W(DST_W), .PAGE(PAGE)) dut (
        .clk(clk), .rst_n(rst_n), .ptr_wr_en(ptr_wr_en), .ptr_wr_data(ptr_wr_data),
        .ptr_inc(ptr_inc), .ptr_dec(ptr_dec), .rd_req(rd_req), .rd_dst(rd_dst),
        .pm_rd_en(pm_rd_en), .pm_addr(pm_addr), .pm_rd_data(pm_rd_data),
        .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
        .ptr_q(ptr_q), .hi_q(hi_q), .busy(busy)
    );

    function automatic logic [WORD_W-1:0] pm_word(input logic [ADDR_W-1:0] a);
        logic [WORD_W-1:0] t;
        t = WORD_W'(a[7:0]) * 14'd73;
        return t ^ 14'h2A5 ^ {a[5:0], 8'h00} ^ WORD_W'(a[11:8]);
    endfunction

    // behavioural program memory with one cycle of read latency
    always @(posedge clk) begin
        if (pm_rd_en) begin
            pm_rd_data <= pm_word(pm_addr);
            rd_cnt <= rd_cnt + 1;
        end
        if (wb_en) wb_cnt <= wb_cnt + 1;
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic load_ptr(input logic [7:0] v);
        @(negedge clk);
        ptr_wr_en = 1'b1; ptr_wr_data = v;
        @(negedge clk);
        ptr_wr_en = 1'b0;
    endtask

    // full read with checks; starts and ends at a negedge
    task automatic do_read(input logic [7:0] p, input logic [DST_W-1:0] d);
        logic [WORD_W-1:0] w;
        w = pm_word({PAGE, p});
        rd_req = 1'b1; rd_dst = d;
        @(negedge clk);
        rd_req = 1'b0;
        chk("R4 pm_rd_en", 32'(pm_rd_en), 1);
        chk("R4 pm_addr", 32'(pm_addr), 32'({PAGE, p}));
        chk("R7 busy issue", 32'(busy), 1);
        @(negedge clk);
        chk("R5 wb_en", 32'(wb_en), 1);
        chk("R5 wb_addr", 32'(wb_addr), 32'(d));
        chk("R5 wb_data", 32'(wb_data), 32'(w[7:0]));
        @(negedge clk);
        chk("R6 hi_q", 32'(hi_q), {26'd0, w[13:8]});
        chk("R7 busy idle", 32'(busy), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int c0;
        int w0;
        logic [WORD_W-1:0] w;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ptr_q", 32'(ptr_q), 0);
        chk("R1 hi_q", 32'(hi_q), 0);
        chk("R1 busy", 32'(busy), 0);
        chk("R1 pm_rd_en", 32'(pm_rd_en), 0);
        chk("R1 wb_en", 32'(wb_en), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // vector walk: R2 load then R4/R5/R6 read
        for (int i = 0; i < NVEC; i++) begin
            load_ptr(VEC[i][14:7]);
            chk("R2 load", 32'(ptr_q), 32'(VEC[i][14:7]));
            do_read(VEC[i][14:7], VEC[i][6:0]);
        end

        // R3 wrap up, wrap down, cancel
        load_ptr(8'hFF);
        ptr_inc = 1'b1; @(negedge clk); ptr_inc = 1'b0;
        chk("R3 inc wrap", 32'(ptr_q), 32'h00);
        ptr_dec = 1'b1; @(negedge clk); ptr_dec = 1'b0;
        chk("R3 dec wrap", 32'(ptr_q), 32'hFF);
        ptr_inc = 1'b1; ptr_dec = 1'b1; @(negedge clk);
        ptr_inc = 1'b0; ptr_dec = 1'b0;
        chk("R3 inc+dec hold", 32'(ptr_q), 32'hFF);
        // R2 load wins over steps
        ptr_wr_en = 1'b1; ptr_wr_data = 8'h3C; ptr_inc = 1'b1; ptr_dec = 1'b0;
        @(negedge clk);
        ptr_wr_en = 1'b0; ptr_inc = 1'b0;
        chk("R2 load priority", 32'(ptr_q), 32'h3C);

        // R4 write in request cycle does not move the address
        ptr_wr_en = 1'b1; ptr_wr_data = 8'hC3;
        rd_req = 1'b1; rd_dst = 7'h11;
        @(negedge clk);
        ptr_wr_en = 1'b0; rd_req = 1'b0;
        chk("R4 addr old ptr", 32'(pm_addr), 32'({PAGE, 8'h3C}));
        chk("R2 ptr new", 32'(ptr_q), 32'hC3);
        // R8 step pointer during the access
        ptr_inc = 1'b1;
        @(negedge clk);
        ptr_inc = 1'b0;
        w = pm_word({PAGE, 8'h3C});
        chk("R8 wb_data unaffected", 32'(wb_data), 32'(w[7:0]));
        chk("R8 ptr stepped", 32'(ptr_q), 32'hC4);
        @(negedge clk);
        chk("R8 hi_q unaffected", 32'(hi_q), {26'd0, w[13:8]});

        // R6 hi_q holds across pointer activity
        load_ptr(8'h00);
        ptr_dec = 1'b1; @(negedge clk); ptr_dec = 1'b0;
        chk("R6 hi_q hold", 32'(hi_q), {26'd0, w[13:8]});

        // R7 request held high while busy starts only one access
        load_ptr(8'h21);
        c0 = rd_cnt; w0 = wb_cnt;
        rd_req = 1'b1; rd_dst = 7'h05;
        @(negedge clk);
        rd_dst = 7'h66;
        @(negedge clk);
        chk("R7 wb_addr first dst", 32'(wb_addr), 32'h05);
        rd_dst = 7'h77;
        @(negedge clk);
        rd_req = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 one read", 32'(rd_cnt - c0), 1);
        chk("R7 one writeback", 32'(wb_cnt - w0), 1);
        chk("R7 idle after", 32'(busy), 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule